// File: doc/BRIEF.md
# Double-Rate Byte Serializer with Word-Phase Recovery

This block joins a 16-bit datapath clocked by a word clock to an 8-bit single-data-rate PHY bus clocked by a fast clock at exactly twice that rate. On transmit, each 16-bit word is registered in the word domain as a high byte and a low byte. The block then emits the two bytes on consecutive fast cycles: low byte first, high byte second. On receive, it takes two consecutive PHY bytes and reassembles them into one 16-bit word, flagged by a single-cycle valid pulse in the fast domain.

The block has no handshake between the two clocks. A flag register flips on every word-clock edge. The fast domain synchronizes that flag and watches for it to change. Each change marks the first fast cycle of a word period, and this recovered phase alone decides which byte slot is active. A lock qualifier watches that the changes arrive exactly every second fast cycle. Until they do, the transmit bus is held at zero and no received word is reported. The forwarded transmit clock is the fast clock inverted, so each byte is launched half a fast cycle ahead of the edge the PHY samples on.

Both clocks share one synchronous active-high reset, which must be held across several word-clock edges.

Top module: `byte_serdes_x2`

## Requirements
- R1: A word on `tx_word` captured at word-clock rising edge E leaves on `phy_tx_data` as follows. Bits 7:0 are driven from the fast edge one fast period after E, while the word clock is low. Bits 15:8 are driven during the following fast cycle, while the word clock is high.
- R2: `phy_tx_clk` is always the logical inverse of `clk_fast`.
- R3: After reset, `locked` rises once two phase marks have been seen exactly two fast cycles apart. While `locked` is low, and for the cycle after it falls, `phy_tx_data` is zero.
- R4: A byte driven on `phy_rx_data` during the fast cycle that starts at a word-clock rising edge becomes `rx_word[7:0]`. The byte in the next fast cycle becomes `rx_word[15:8]`. The assembled word appears with `rx_valid` high for one fast cycle, one fast edge after the high byte is sampled.
- R5: `rx_valid` is never high on two consecutive fast cycles, and it is high only if `locked` was high in the previous cycle.
- R6: If the word clock stops, `locked` falls within six fast cycles. From then on, `phy_tx_data` stays zero and `rx_valid` stays low.
- R7: While `rst` is high, `locked`, `rx_valid` and `phy_tx_data` are all zero.
- R8: When the word clock resumes after a stop, `locked` returns, and both directions again carry words with the byte order of R1 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_word | input | 1 | Word clock, half the fast rate, rising edges aligned to fast rising edges |
| clk_fast | input | 1 | Fast byte clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| tx_word | input | 2*BYTE_W | Transmit word, sampled on `clk_word` |
| phy_tx_data | output | BYTE_W | Registered transmit byte to the PHY |
| phy_tx_clk | output | 1 | Forwarded transmit clock, inverse of `clk_fast` |
| phy_rx_data | input | BYTE_W | Receive byte from the PHY, sampled on `clk_fast` |
| rx_word | output | 2*BYTE_W | Reassembled receive word, fast domain |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |
| locked | output | 1 | Word phase recovered and stable |

## Verification
The hardest situation to reach from the ports is the loss and recovery of the word phase in the middle of traffic. The bench reaches it by generating the word clock from the fast clock through an enable that it can drop and later restore. The stop is placed at an arbitrary word-clock level, and the bench checks that lock falls, both buses go quiet, lock comes back, and byte ordering is correct again on both paths. Scoreboard queues compare every transmitted and received word against the order stated in R1 and R4.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  // Fast-domain byte slot inside one word period.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_LO   = 2'd1,
    SLOT_HI   = 2'd2
  } slot_e;

endpackage

// File: rtl/dbs_word_capture.sv
// Word-domain capture: splits the word into byte halves and flips a phase
// flag on every word edge so the fast domain can find the word boundary.
module dbs_word_capture #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_word,
  input  logic                rst,
  input  logic [2*BYTE_W-1:0] word_in,
  output logic [BYTE_W-1:0]   hi_q,
  output logic [BYTE_W-1:0]   lo_q,
  output logic                toggle_q
);

  always_ff @(posedge clk_word) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      toggle_q <= 1'b0;
    end else begin
      hi_q     <= word_in[2*BYTE_W-1:BYTE_W];
      lo_q     <= word_in[BYTE_W-1:0];
      toggle_q <= ~toggle_q;
    end
  end

endmodule

// File: rtl/dbs_phase_det.sv
// Fast-domain phase recovery: synchronizes the word toggle, marks each change
// as the low-byte slot and qualifies lock on regular two-cycle spacing.
module dbs_phase_det
  import dbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_EDGES  = 2
) (
  input  logic  clk_fast,
  input  logic  rst,
  input  logic  toggle_in,
  output slot_e slot,
  output logic  locked
);

  localparam int CNT_W = $clog2(LOCK_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_EDGES);
  localparam logic [1:0] GAP_MAX = 2'd3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   sec_q;
  logic                   mark_w;
  logic [1:0]             gap_q;
  logic [1:0]             gap_nxt;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       cnt_nxt;
  logic                   locked_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk_fast) begin
        if (rst) sync_q <= '0;
        else     sync_q <= toggle_in;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk_fast) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], toggle_in};
      end
    end
  endgenerate

  assign mark_w = sync_q[SYNC_STAGES-1] ^ prev_q;

  always_comb begin
    cnt_nxt = cnt_q;
    gap_nxt = (gap_q == GAP_MAX) ? GAP_MAX : gap_q + 2'd1;
    if (mark_w) begin
      gap_nxt = 2'd0;
      if (gap_q == 2'd1) cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
      else               cnt_nxt = CNT_W'(1);
    end else if (gap_q != 2'd0) begin
      cnt_nxt = '0;
    end
  end

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      prev_q   <= 1'b0;
      sec_q    <= 1'b0;
      gap_q    <= GAP_MAX;
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      prev_q   <= sync_q[SYNC_STAGES-1];
      sec_q    <= mark_w;
      gap_q    <= gap_nxt;
      cnt_q    <= cnt_nxt;
      locked_q <= (cnt_nxt == CNT_MAX);
    end
  end

  assign slot   = mark_w ? SLOT_LO : (sec_q ? SLOT_HI : SLOT_IDLE);
  assign locked = locked_q;

endmodule

// File: rtl/dbs_tx_seq.sv
// Transmit sequencer: low byte in the LO slot, staged high byte in HI slot.
module dbs_tx_seq
  import dbs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_fast,
  input  logic              rst,
  input  slot_e             slot,
  input  logic              locked,
  input  logic [BYTE_W-1:0] hi_in,
  input  logic [BYTE_W-1:0] lo_in,
  output logic [BYTE_W-1:0] tx_q
);

  logic [BYTE_W-1:0] hi_stage_q;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      tx_q       <= '0;
      hi_stage_q <= '0;
    end else begin
      unique case (slot)
        SLOT_LO: begin
          hi_stage_q <= hi_in;
          tx_q       <= locked ? lo_in : '0;
        end
        SLOT_HI: tx_q <= locked ? hi_stage_q : '0;
        default: tx_q <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dbs_rx_pack.sv
// Receive packer: first byte of a word period is the low half.
module dbs_rx_pack
  import dbs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_fast,
  input  logic                rst,
  input  slot_e               slot,
  input  logic                locked,
  input  logic [BYTE_W-1:0]   rx_in,
  output logic [2*BYTE_W-1:0] word_q,
  output logic                valid_q
);

  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      lo_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (slot == SLOT_LO) lo_q <= rx_in;
      if (slot == SLOT_HI) begin
        word_q  <= {rx_in, lo_q};
        valid_q <= locked;
      end
    end
  end

endmodule

// File: rtl/byte_serdes_x2.sv
module byte_serdes_x2
  import dbs_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_EDGES  = 2
) (
  input  logic                clk_word,
  input  logic                clk_fast,
  input  logic                rst,
  input  logic [2*BYTE_W-1:0] tx_word,
  output logic [BYTE_W-1:0]   phy_tx_data,
  output logic                phy_tx_clk,
  input  logic [BYTE_W-1:0]   phy_rx_data,
  output logic [2*BYTE_W-1:0] rx_word,
  output logic                rx_valid,
  output logic                locked
);

  logic [BYTE_W-1:0] cap_hi_w;
  logic [BYTE_W-1:0] cap_lo_w;
  logic              toggle_w;
  slot_e             slot_w;

  dbs_word_capture #(.BYTE_W(BYTE_W)) u_capture (
    .clk_word (clk_word),
    .rst      (rst),
    .word_in  (tx_word),
    .hi_q     (cap_hi_w),
    .lo_q     (cap_lo_w),
    .toggle_q (toggle_w)
  );

  dbs_phase_det #(.SYNC_STAGES(SYNC_STAGES), .LOCK_EDGES(LOCK_EDGES)) u_phase (
    .clk_fast  (clk_fast),
    .rst       (rst),
    .toggle_in (toggle_w),
    .slot      (slot_w),
    .locked    (locked)
  );

  dbs_tx_seq #(.BYTE_W(BYTE_W)) u_tx (
    .clk_fast (clk_fast),
    .rst      (rst),
    .slot     (slot_w),
    .locked   (locked),
    .hi_in    (cap_hi_w),
    .lo_in    (cap_lo_w),
    .tx_q     (phy_tx_data)
  );

  dbs_rx_pack #(.BYTE_W(BYTE_W)) u_rx (
    .clk_fast (clk_fast),
    .rst      (rst),
    .slot     (slot_w),
    .locked   (locked),
    .rx_in    (phy_rx_data),
    .word_q   (rx_word),
    .valid_q  (rx_valid)
  );

  // Launch on the fast rising edge, PHY samples on the inverted clock's rise.
  assign phy_tx_clk = ~clk_fast;

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker
  import dbs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk_fast,
  input logic              rst,
  input logic              locked,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] phy_tx_data,
  input slot_e             slot
);

  assert_tx_quiet_unlocked_R3: assert property (@(posedge clk_fast) disable iff (rst)
    (!locked && !$past(locked)) |-> (phy_tx_data == '0));

  assert_lock_on_mark_R3: assert property (@(posedge clk_fast) disable iff (rst)
    $rose(locked) |-> ($past(slot) == SLOT_LO));

  assert_valid_single_R5: assert property (@(posedge clk_fast) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_valid_needs_lock_R5: assert property (@(posedge clk_fast) disable iff (rst)
    rx_valid |-> $past(locked));

  assert_drop_on_missing_mark_R6: assert property (@(posedge clk_fast) disable iff (rst)
    (locked && slot == SLOT_IDLE && $past(slot) == SLOT_HI) |=> !locked);

endmodule

bind byte_serdes_x2 dbs_checker #(.BYTE_W(BYTE_W)) u_dbs_checker (
  .clk_fast    (clk_fast),
  .rst         (rst),
  .locked      (locked),
  .rx_valid    (rx_valid),
  .phy_tx_data (phy_tx_data),
  .slot        (slot_w)
);

// File: tb/test_byte_serdes_x2.sv
`timescale 1ns/1ps
module test_byte_serdes_x2;

  logic        clk_fast = 1'b0;
  logic        clk_word = 1'b0;
  logic        word_run = 1'b1;
  logic        rst      = 1'b1;
  logic [15:0] tx_word  = '0;
  logic [7:0]  phy_rx_data = '0;
  logic [7:0]  phy_tx_data;
  logic        phy_tx_clk;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic        locked;

  int tests = 0;
  int fails = 0;
  int tx_hits = 0;
  int rx_hits = 0;
  bit done = 1'b0;

  logic [15:0] txq[$];
  logic [15:0] rxq[$];

  always #2 clk_fast = ~clk_fast;
  always @(posedge clk_fast) if (word_run) clk_word <= ~clk_word;

  byte_serdes_x2 i_byte_serdes_x2 (
    .clk_word    (clk_word),
    .clk_fast    (clk_fast),
    .rst         (rst),
    .tx_word     (tx_word),
    .phy_tx_data (phy_tx_data),
    .phy_tx_clk  (phy_tx_clk),
    .phy_rx_data (phy_rx_data),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid),
    .locked      (locked)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drivers: push the expected word once it is committed to the design.
  task automatic tx_send(input logic [15:0] w);
    @(negedge clk_word);
    tx_word = w;
    @(posedge clk_word);
    #1;
    txq.push_back(w);
  endtask

  task automatic rx_send(input logic [15:0] w);
    @(posedge clk_word);
    @(negedge clk_fast);
    phy_rx_data = w[7:0];
    @(negedge clk_fast);
    phy_rx_data = w[15:8];
    rxq.push_back(w);
  endtask

  // Monitor / scoreboard
  logic [7:0]  lo_s;
  bit          have_lo = 1'b0;
  logic [15:0] exp_w;
  always @(negedge clk_fast) begin
    if (locked && !clk_word && txq.size() > 0) begin
      lo_s    = phy_tx_data;
      have_lo = 1'b1;
    end else if (have_lo && clk_word) begin
      have_lo = 1'b0;
      exp_w = txq.pop_front();
      check({phy_tx_data, lo_s} == exp_w, "R1 tx byte order", {phy_tx_data, lo_s}, exp_w);
      tx_hits++;
    end
    if (rx_valid && rxq.size() > 0) begin
      exp_w = rxq.pop_front();
      check(rx_word == exp_w, "R4 rx pairing", rx_word, exp_w);
      rx_hits++;
    end
  end

  task automatic burst(input int n, input logic [15:0] seed);
    fork
      for (int i = 0; i < n; i++) tx_send(16'(i * 16'h1357) ^ seed);
      for (int j = 0; j < n; j++) rx_send(16'(j * 16'h0B3D) ^ ~seed);
    join
    while (txq.size() != 0 || rxq.size() != 0) @(negedge clk_fast);
    repeat (4) @(negedge clk_fast);
  endtask

  initial begin
    bit bad;
    bit got;
    int prev_tx;
    int prev_rx;
    // R7: reset state
    repeat (10) @(negedge clk_fast);
    check(locked == 1'b0, "R7 locked in reset", 16'(locked), 16'h0);
    check(phy_tx_data == 8'h0, "R7 tx in reset", 16'(phy_tx_data), 16'h0);
    check(rx_valid == 1'b0, "R7 rx_valid in reset", 16'(rx_valid), 16'h0);
    tx_word = 16'hDEAD;
    phy_rx_data = 8'h5A;
    rst = 1'b0;

    // R3: no traffic before lock, lock reached
    bad = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_fast);
      if (locked) begin got = 1'b1; break; end
      if (phy_tx_data != 8'h0) bad = 1'b1;
    end
    check(got, "R3 lock acquired", 16'(got), 16'h1);
    check(!bad, "R3 tx zero before lock", 16'(bad), 16'h0);

    // R2: forwarded clock
    @(negedge clk_fast);
    check(phy_tx_clk == 1'b1, "R2 tx clk while fast low", 16'(phy_tx_clk), 16'h1);
    @(posedge clk_fast); #1;
    check(phy_tx_clk == 1'b0, "R2 tx clk while fast high", 16'(phy_tx_clk), 16'h0);

    // R1, R4: directed corner words then a computed run
    fork
      begin
        tx_send(16'h1234); tx_send(16'h00FF); tx_send(16'hFF00);
        tx_send(16'h0000); tx_send(16'hFFFF); tx_send(16'hA55A);
      end
      begin
        rx_send(16'hBEEF); rx_send(16'h0001); rx_send(16'h8000);
        rx_send(16'hFFFF); rx_send(16'h0000); rx_send(16'h3CC3);
      end
    join
    while (txq.size() != 0 || rxq.size() != 0) @(negedge clk_fast);
    burst(24, 16'hA5A5);
    check(tx_hits == 30, "R1 tx word count", 16'(tx_hits), 16'd30);
    check(rx_hits == 30, "R4 rx word count", 16'(rx_hits), 16'd30);

    // R6, R5: stop the word clock
    word_run = 1'b0;
    repeat (6) @(negedge clk_fast);
    check(locked == 1'b0, "R6 lock dropped", 16'(locked), 16'h0);
    bad = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_fast);
      if (phy_tx_data != 8'h0) bad = 1'b1;
      if (rx_valid) got = 1'b1;
    end
    check(!bad, "R6 tx quiet while stopped", 16'(bad), 16'h0);
    check(!got, "R5 no rx_valid while unlocked", 16'(got), 16'h0);

    // R8: resume and relock
    word_run = 1'b1;
    got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_fast);
      if (locked) begin got = 1'b1; break; end
    end
    check(got, "R8 relock", 16'(got), 16'h1);
    prev_tx = tx_hits;
    prev_rx = rx_hits;
    burst(16, 16'h5AC3);
    check(tx_hits - prev_tx == 16, "R8 tx after relock", 16'(tx_hits - prev_tx), 16'd16);
    check(rx_hits - prev_rx == 16, "R8 rx after relock", 16'(rx_hits - prev_rx), 16'd16);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule